// File: doc/BRIEF.md
# Sixteen-bit timer with three compare channels and force strobes

The block is an up-counting 16-bit timer with three output-compare channels. Each channel compares the running count against its own 16-bit compare value. On a match the channel raises a sticky flag and drives its waveform pin according to a 2-bit output action. The counter advances only on cycles where the timer-clock enable is high. In the clear-on-top mode it restarts from zero after reaching the value held by channel 0.

Software reaches every register through an 8-bit register bus. The counter and the three compare values are 16 bits wide. They are transferred through one temporary byte latch, shared by all of them, so that a 16-bit value always changes or is sampled as a whole.

A force register lets software apply a channel's output action at once, without waiting for a match. A forced action changes only the pin: it touches neither the flags nor the counter. A software write to the counter suppresses every compare match on the timer tick that follows.

The bus is plain control and status, not a data stream, so it has no valid/ready handshake. A read returns data in the same cycle, combinationally. A write takes effect at the next clock edge.

Top module: `cmp_timer16`

## Requirements
- R1: After reset the counter, all compare values, the mode, the output actions, the temporary latch, all flags and all waveform pins are zero.
- R2: The register map is 0 mode, 1 output actions, 2 force, 3 flags, 4/5 counter low/high, and 6+2i/7+2i compare i low/high. Writing any high address loads the shared temporary latch. Writing a low address commits {latch, data} to that 16-bit register in one cycle. Reading a low address returns the low byte and copies that register's high byte into the latch. Reading any high address returns the latch.
- R3: The counter increments by one, wrapping from 0xFFFF to 0, on each cycle where tick_en is high. It holds its value when tick_en is low.
- R4: In mode 01 (clear on top), compare 0 is TOP. A tick while the counter equals TOP returns the counter to 0 and sets flag 0. Mode 00 is free running.
- R5: A tick while the counter equals compare i sets flag i (bit i of address 3 and of match_flag) in the next cycle. Writing 1 to a flag bit clears it. A new match in the same cycle wins over the clear.
- R6: Channel i's action is bits [2i+1:2i] of address 1, encoded as 00 no change, 01 toggle, 10 drive low, 11 drive high. It is applied to wave_out[i] on every match.
- R7: In modes 00 and 01, writing 1 to bit i of address 2 applies channel i's current action to wave_out[i] at that clock edge, whether or not tick_en is high.
- R8: A forced action sets no flag and neither clears nor alters the counter. This holds in mode 01 even when the counter equals TOP.
- R9: In modes 10 and 11, writes to address 2 have no effect on the pins. Address 2 always reads as zero.
- R10: After a software write to the counter, the next tick produces no match on any channel: no flag, no pin action and no clear on top. That tick still increments the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timer-clock enable; the counter advances when high |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_rd is high, zero otherwise |
| match_flag | output | 3 | Sticky compare-match flags, one per channel |
| wave_out | output | 3 | Waveform pins, one per channel |

## Verification
The properties assume that software never raises cpu_wr and cpu_rd in the same cycle. They also assume that the counter is changed only through writes to address 4. The stimulus issues one bus access at a time, each followed by an idle cycle. tick_en is held low during bus accesses unless a sequence needs a tick and an access to coincide. Under these rules, every edge of the design can be predicted from the bus traffic and the enable alone, which is what the reference model relies on.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] RA_MODE     = 4'd0;
  localparam logic [ADDR_W-1:0] RA_COUT     = 4'd1;
  localparam logic [ADDR_W-1:0] RA_FORCE    = 4'd2;
  localparam logic [ADDR_W-1:0] RA_FLAG     = 4'd3;
  localparam logic [ADDR_W-1:0] RA_CNT_LO   = 4'd4;
  localparam logic [ADDR_W-1:0] RA_CNT_HI   = 4'd5;
  localparam int                RA_CMP_BASE = 6;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_CTC    = 2'b01,
    WM_WAVE_A = 2'b10,
    WM_WAVE_B = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    CO_OFF    = 2'b00,
    CO_TOGGLE = 2'b01,
    CO_LOW    = 2'b10,
    CO_HIGH   = 2'b11
  } cout_e;

  function automatic logic next_level(cout_e act, logic cur);
    case (act)
      CO_TOGGLE: return ~cur;
      CO_LOW:    return 1'b0;
      CO_HIGH:   return 1'b1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmpt_busif.sv
module cmpt_busif
  import cmpt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_wr,
  input  logic                        cpu_rd,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [BYTE_W-1:0]           cpu_wdata,
  output logic [BYTE_W-1:0]           cpu_rdata,
  input  logic [CNT_W-1:0]            cnt_q,
  input  logic [NCH-1:0]              flag_q,
  output wmode_e                      mode_q,
  output logic [2*NCH-1:0]            cout_q,
  output logic [NCH-1:0][CNT_W-1:0]   cmp_q,
  output logic                        cnt_wr,
  output logic [CNT_W-1:0]            cnt_wval,
  output logic [NCH-1:0]              force_p,
  output logic [NCH-1:0]              flag_clr
);
  logic [BYTE_W-1:0] temp_q;
  logic [NCH-1:0]    cmp_lo_sel, cmp_hi_sel;
  logic              wide_lo, wide_hi;
  logic [BYTE_W-1:0] lo_high_byte;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign cmp_lo_sel[i] = (cpu_addr == ADDR_W'(RA_CMP_BASE + 2*i));
    assign cmp_hi_sel[i] = (cpu_addr == ADDR_W'(RA_CMP_BASE + 2*i + 1));
  end

  // Which 16-bit half is addressed, and the high byte a low read captures
  always_comb begin
    wide_lo      = (cpu_addr == RA_CNT_LO);
    wide_hi      = (cpu_addr == RA_CNT_HI);
    lo_high_byte = cnt_q[CNT_W-1:BYTE_W];
    for (int i = 0; i < NCH; i++) begin
      if (cmp_lo_sel[i]) begin
        wide_lo      = 1'b1;
        lo_high_byte = cmp_q[i][CNT_W-1:BYTE_W];
      end
      if (cmp_hi_sel[i]) wide_hi = 1'b1;
    end
  end

  assign cnt_wr   = cpu_wr && (cpu_addr == RA_CNT_LO);
  assign cnt_wval = {temp_q, cpu_wdata};
  assign force_p  = (cpu_wr && (cpu_addr == RA_FORCE) && !mode_q[1]) ? cpu_wdata[NCH-1:0] : '0;
  assign flag_clr = (cpu_wr && (cpu_addr == RA_FLAG)) ? cpu_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      mode_q <= WM_NORMAL;
      cout_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (cpu_wr && wide_hi)      temp_q <= cpu_wdata;
      else if (cpu_rd && wide_lo) temp_q <= lo_high_byte;
      if (cpu_wr && (cpu_addr == RA_MODE)) mode_q <= wmode_e'(cpu_wdata[1:0]);
      if (cpu_wr && (cpu_addr == RA_COUT)) cout_q <= cpu_wdata[2*NCH-1:0];
      for (int i = 0; i < NCH; i++)
        if (cpu_wr && cmp_lo_sel[i]) cmp_q[i] <= {temp_q, cpu_wdata};
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (cpu_addr == RA_MODE)        cpu_rdata = BYTE_W'(mode_q);
      else if (cpu_addr == RA_COUT)   cpu_rdata = BYTE_W'(cout_q);
      else if (cpu_addr == RA_FLAG)   cpu_rdata = BYTE_W'(flag_q);
      else if (cpu_addr == RA_CNT_LO) cpu_rdata = cnt_q[BYTE_W-1:0];
      else if (wide_hi)               cpu_rdata = temp_q;
      for (int i = 0; i < NCH; i++)
        if (cmp_lo_sel[i]) cpu_rdata = cmp_q[i][BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter
  import cmpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr_at_top,
  input  logic [CNT_W-1:0] top,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_en,
  output logic             blk_q
);
  // A match may only be taken on a tick that is neither overridden by a
  // software write nor the first tick after one.
  assign match_en = tick_en && !blk_q && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (cnt_wr) begin
      cnt_q <= cnt_wval;
      blk_q <= 1'b1;
    end else if (tick_en) begin
      blk_q <= 1'b0;
      if (match_en && clr_at_top && (cnt_q == top)) cnt_q <= '0;
      else                                          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmpt_chan.sv
module cmpt_chan
  import cmpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match_en,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cmp,
  input  cout_e            act,
  input  logic             force_p,
  input  logic             flag_clr,
  output logic             flag_q,
  output logic             wave_q
);
  logic hit;
  assign hit = match_en && (cnt_q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~flag_clr);
      if (hit || force_p) wave_q <= next_level(act, wave_q);
    end
  end
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
  import cmpt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic [NCH-1:0]    match_flag,
  output logic [NCH-1:0]    wave_out
);
  wmode_e                    mode_q;
  logic [2*NCH-1:0]          cout_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic                      cnt_wr;
  logic [CNT_W-1:0]          cnt_wval, cnt_q;
  logic [NCH-1:0]            force_p, flag_clr;
  logic                      match_en, blk_q;

  cmpt_busif #(.NCH(NCH)) u_bus (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cnt_q(cnt_q), .flag_q(match_flag), .mode_q(mode_q), .cout_q(cout_q),
    .cmp_q(cmp_q), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
    .force_p(force_p), .flag_clr(flag_clr)
  );

  cmpt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .clr_at_top(mode_q == WM_CTC), .top(cmp_q[0]),
    .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .cnt_q(cnt_q),
    .match_en(match_en), .blk_q(blk_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmpt_chan u_ch (
      .clk(clk), .rst_n(rst_n), .match_en(match_en), .cnt_q(cnt_q),
      .cmp(cmp_q[i]), .act(cout_e'(cout_q[2*i +: 2])),
      .force_p(force_p[i]), .flag_clr(flag_clr[i]),
      .flag_q(match_flag[i]), .wave_q(wave_out[i])
    );
  end
endmodule

module cmpt_chk
  import cmpt_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              cpu_rd,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [BYTE_W-1:0] cpu_rdata,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  top,
  input logic              blk,
  input logic              cnt_wr,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    wave
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && mode != 2'b01) |=> cnt == $past(cnt) + 16'd1);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt));
  // R4
  ctc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && !blk && mode == 2'b01 && cnt == top) |=> cnt == '0);
  // R8
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (flags & ~$past(flags)) == '0);
  // R10
  blocked_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tick_en) |=> (flags & ~$past(flags)) == '0);
  // R9
  force_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == RA_FORCE) |-> cpu_rdata == '0);
  // R9
  wave_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !tick_en) |=> $stable(wave));
endmodule

bind cmp_timer16 cmpt_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .mode(mode_q),
  .cnt(cnt_q), .top(cmp_q[0]), .blk(blk_q), .cnt_wr(cnt_wr),
  .flags(match_flag), .wave(wave_out)
);

// File: tb/test_cmp_timer16.sv
`timescale 1ns/1ps
module test_cmp_timer16;
  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [2:0] match_flag, wave_out;

  int n_tests = 0, n_fail = 0;
  bit running = 1'b0;

  // reference model state
  int m_cnt, m_blk, m_temp, m_mode, m_com, m_flag, m_wave;
  int m_cmp[3];

  always #2.5 clk = ~clk;

  cmp_timer16 i_cmp_timer16 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .match_flag(match_flag), .wave_out(wave_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_mode;
      1: return m_com;
      3: return m_flag;
      4: return m_cnt % 256;
      5, 7, 9, 11: return m_temp;
      6, 8, 10: return m_cmp[(a-6)/2] % 256;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int o_cnt, hit, frc, clr, act;
    if (!rst_n) begin
      m_cnt = 0; m_blk = 0; m_temp = 0; m_mode = 0; m_com = 0; m_flag = 0; m_wave = 0;
      for (int i = 0; i < 3; i++) m_cmp[i] = 0;
    end else begin
      o_cnt = m_cnt; hit = 0; frc = 0; clr = 0;
      for (int i = 0; i < 3; i++)
        if (tick_en && m_blk == 0 && !(cpu_wr && cpu_addr == 4) && m_cnt == m_cmp[i]) hit |= (1 << i);
      if (cpu_wr && cpu_addr == 2 && m_mode < 2) frc = cpu_wdata & 7;
      if (cpu_wr && cpu_addr == 3) clr = cpu_wdata & 7;
      if (cpu_wr && cpu_addr == 4) begin
        m_cnt = m_temp * 256 + cpu_wdata; m_blk = 1;
      end else if (tick_en) begin
        if (m_blk == 0 && m_mode == 1 && m_cnt == m_cmp[0]) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % 65536;
        m_blk = 0;
      end
      m_flag = (m_flag & ~clr) | hit;
      for (int i = 0; i < 3; i++)
        if (((hit | frc) >> i) & 1) begin
          act = (m_com >> (2*i)) & 3;
          if (act == 1) m_wave ^= (1 << i);
          else if (act == 2) m_wave &= ~(1 << i);
          else if (act == 3) m_wave |= (1 << i);
        end
      if (cpu_wr) begin
        if (cpu_addr == 0) m_mode = cpu_wdata & 3;
        if (cpu_addr == 1) m_com = cpu_wdata & 63;
        if (cpu_addr == 6 || cpu_addr == 8 || cpu_addr == 10)
          m_cmp[(cpu_addr-6)/2] = m_temp * 256 + cpu_wdata;
        if (cpu_addr == 5 || cpu_addr == 7 || cpu_addr == 9 || cpu_addr == 11) m_temp = cpu_wdata;
      end else if (cpu_rd) begin
        if (cpu_addr == 4) m_temp = o_cnt / 256;
        if (cpu_addr == 6 || cpu_addr == 8 || cpu_addr == 10) m_temp = m_cmp[(cpu_addr-6)/2] / 256;
      end
    end
  end

  // per-cycle comparison of registered outputs against the model (R5 R6)
  always @(negedge clk)
    if (running)
      check({match_flag, wave_out} == 6'((m_flag << 3) | m_wave), "R5 R6 model",
            {match_flag, wave_out}, (m_flag << 3) | m_wave);

  task automatic wr(input int a, input int d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = 4'(a); cpu_wdata = 8'(d);
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int lit, input string req);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = 4'(a);
    #1;
    check(int'(cpu_rdata) == exp_rd(a), {req, " model"}, cpu_rdata, exp_rd(a));
    if (lit >= 0) check(int'(cpu_rdata) == lit, req, cpu_rdata, lit);
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic out_chk(input int fl, input int wv, input string req);
    #1;
    check(int'(match_flag) == fl, {req, " flags"}, match_flag, fl);
    check(int'(wave_out) == wv, {req, " wave"}, wave_out, wv);
  endtask

  initial begin
    #(5.0 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1 reset state
    out_chk(0, 0, "R1");
    rd_chk(4, 0, "R1"); rd_chk(5, 0, "R1"); rd_chk(6, 0, "R1"); rd_chk(0, 0, "R1");
    // R2 byte access through the shared latch
    wr(7, 8'h12); wr(6, 8'h34);
    rd_chk(6, 8'h34, "R2"); rd_chk(7, 8'h12, "R2");
    wr(9, 8'hAB); wr(10, 8'hCD);
    rd_chk(10, 8'hCD, "R2"); rd_chk(11, 8'hAB, "R2");
    // R3 counting, holding and wrapping
    wr(5, 1); wr(4, 2);
    ticks(10);
    rd_chk(4, 8'h0C, "R3"); rd_chk(5, 8'h01, "R3");
    repeat (5) @(negedge clk);
    rd_chk(4, 8'h0C, "R3");
    wr(5, 8'hFF); wr(4, 8'hFE);
    ticks(3);
    rd_chk(4, 1, "R3"); rd_chk(5, 0, "R3");
    // R5 R6 real matches with toggle, high and low actions
    wr(3, 7); out_chk(0, 0, "R5");
    wr(7, 0); wr(6, 8'h10); wr(9, 0); wr(8, 8'h10); wr(11, 0); wr(10, 8'h10);
    wr(1, 8'h2D);
    wr(5, 0); wr(4, 8'h0C);
    ticks(5);
    out_chk(7, 3'b011, "R6");
    wr(3, 1); out_chk(6, 3'b011, "R5");
    // R10 counter write blocks the next tick's match
    wr(3, 7); wr(5, 0); wr(4, 8'h10);
    ticks(1);
    out_chk(0, 3'b011, "R10");
    rd_chk(4, 8'h11, "R10");
    // R4 clear on top, compare 0 = 3
    wr(0, 1); wr(7, 0); wr(6, 3); wr(5, 0); wr(4, 0);
    ticks(10);
    rd_chk(4, 2, "R4");
    #1 check(match_flag[0] == 1'b1, "R4 flag0", match_flag[0], 1);
    // R7 R8 forced actions
    wr(3, 7); wr(1, 8'h3D);
    wr(2, 3'b101);
    out_chk(0, 3'b110, "R7");
    rd_chk(4, 2, "R8");
    wr(5, 0); wr(4, 3); wr(2, 1);
    out_chk(0, 3'b111, "R8");
    rd_chk(4, 3, "R8");
    rd_chk(2, 0, "R9");
    // R9 force ignored in modes 10 and 11
    wr(1, 8'h15);
    wr(0, 2); wr(2, 7); out_chk(0, 3'b111, "R9");
    wr(0, 3); wr(2, 7); out_chk(0, 3'b111, "R9");
    rd_chk(2, 0, "R9");
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule